// File: doc/BRIEF.md
# CPU Reset Exception Sequencer

This block runs the reset exception of a 32-bit processor core. A hardware reset, or a reset request from outside the core or from an on-chip module, aborts whatever the sequencer is doing. The sequencer then puts the status register and the vector base register into their architectural start values. It reads two long words through a simple read-only bus master: the supervisor stack pointer first, then the program counter. Last, it issues the first instruction fetch from the new program counter and enters normal execution. No old program counter or status register is saved anywhere.

Some failures stop the start-up for good. These are a bus error on any of the three start-up bus cycles, and a stack pointer or program counter fetched with an odd value, which counts as an address error. In either case the core stops in a halted state, drives a halt output, and stays there until the next reset request.

Separately, a software reset instruction, accepted only during normal execution, drives an external reset line for a fixed number of cycles and leaves every CPU register untouched.

Top module: `cpu_rst_seq`

## Requirements
- R1: After `rst_ni` is released, and after every reset request, the status register reads 16'h2700 and the vector base register reads 0. In the status register, trace bit T1 is bit 15 and T0 is bit 14, both 0. The supervisor bit is bit 13 and is 1. The interrupt mask is bits 10:8 and is 3'b111. All other bits are 0.
- R2: The sequence first reads byte address 0 into the stack pointer, then reads byte address 4 into the program counter, with `bus_ifetch_o` low for both reads. Each read keeps `bus_req_o` high and `bus_addr_o` stable until `bus_ack_i` or `bus_err_i` arrives, and the data is taken in the cycle of the acknowledge.
- R3: After the program counter is loaded, a request with `bus_ifetch_o` high is issued at the program counter address. `fetch_start_o` is high only in the first cycle of that request. After its acknowledge, `run_o` is high.
- R4: A reset request on `ext_rst_req_i` or `int_rst_req_i` wins over everything else. In the cycle after the request, `bus_req_o`, `run_o`, `halt_o` and `ext_rst_o` are all low. The sequence restarts from the beginning once the request drops.
- R5: `bus_err_i` during the stack pointer read, the program counter read or the first fetch ends the sequence. From the next cycle `halt_o` is high and `bus_req_o` is low.
- R6: A stack pointer or program counter value read with bit 0 set is treated as an address error and leads to the halted state, just as in R5.
- R7: While halted, the block ignores `bus_ack_i` and `sw_rst_req_i`. Only a reset request clears `halt_o`.
- R8: `sw_rst_req_i` during normal execution drives `ext_rst_o` high for exactly RST_CYCLES cycles. `sw_rst_done_o` is high in the single cycle after `ext_rst_o` falls. The four CPU register outputs do not change, and no bus request is made.
- R9: `sw_rst_req_i` has no effect before normal execution is reached. `ext_rst_o` stays low, and the start-up reads continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| ext_rst_req_i | input | 1 | Reset request from outside the core |
| int_rst_req_i | input | 1 | Reset request from an on-chip module |
| sw_rst_req_i | input | 1 | Software reset instruction request |
| bus_req_o | output | 1 | Read request, held until acknowledge or error |
| bus_addr_o | output | 32 | Byte address of the read |
| bus_ifetch_o | output | 1 | Read is an instruction fetch |
| bus_ack_i | input | 1 | Read completed, data valid |
| bus_err_i | input | 1 | Read terminated with a bus error |
| bus_rdata_i | input | 32 | Read data |
| sr_o | output | 16 | Status register |
| vbr_o | output | 32 | Vector base register |
| ssp_o | output | 32 | Supervisor stack pointer |
| pc_o | output | 32 | Program counter |
| fetch_start_o | output | 1 | One-cycle pulse when the first fetch is issued |
| run_o | output | 1 | Normal execution reached |
| halt_o | output | 1 | Halted after a fault in the reset sequence |
| ext_rst_o | output | 1 | External reset line driven by the software reset |
| sw_rst_done_o | output | 1 | Software reset instruction completed |

## Verification
The bus-hold assertion assumes the responder answers only a pending request, and never raises acknowledge and error together. It also assumes the responder never withdraws a request on its own, so any drop in `bus_req_o` must come from an acknowledge, an error or a reset request. The bench responder keeps to this: it drives acknowledge or error for exactly one cycle, and only after it has seen `bus_req_o`. The no-change check on registers during a software reset assumes no reset request arrives in the same cycle. The bench issues its aborting requests only after the sequencer has been observed in the software reset state.

// File: rtl/cpu_rst_seq_pkg.sv
package cpu_rst_seq_pkg;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_RD_SP,
    ST_RD_PC,
    ST_FETCH,
    ST_RUN,
    ST_SWRST,
    ST_HALT
  } seq_state_e;

  localparam int unsigned SR_W       = 16;
  localparam int unsigned SR_T1_BIT  = 15;
  localparam int unsigned SR_T0_BIT  = 14;
  localparam int unsigned SR_S_BIT   = 13;
  localparam int unsigned SR_IPL_LSB = 8;
  localparam int unsigned IPL_W      = 3;

  function automatic logic [SR_W-1:0] sr_reset_val();
    logic [SR_W-1:0] v;
    v = '0;
    v[SR_T1_BIT] = 1'b0;
    v[SR_T0_BIT] = 1'b0;
    v[SR_S_BIT]  = 1'b1;
    v[SR_IPL_LSB +: IPL_W] = '1;
    return v;
  endfunction

endpackage

// File: rtl/cpu_rst_seq_ctrl.sv
module cpu_rst_seq_ctrl
  import cpu_rst_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rst_req_i,
  input  logic       bus_ack_i,
  input  logic       bus_err_i,
  input  logic       addr_odd_i,
  input  logic       sw_req_i,
  input  logic       sw_done_i,
  output seq_state_e state_o,
  output logic       fetch_start_o
);

  seq_state_e state_q, state_d;
  logic       fstart_q;

  always_comb begin
    state_d = state_q;
    if (rst_req_i) begin
      state_d = ST_INIT;
    end else begin
      case (state_q)
        ST_INIT:  state_d = ST_RD_SP;
        ST_RD_SP: begin
          if (bus_err_i || (bus_ack_i && addr_odd_i)) state_d = ST_HALT;
          else if (bus_ack_i)                         state_d = ST_RD_PC;
        end
        ST_RD_PC: begin
          if (bus_err_i || (bus_ack_i && addr_odd_i)) state_d = ST_HALT;
          else if (bus_ack_i)                         state_d = ST_FETCH;
        end
        ST_FETCH: begin
          if (bus_err_i)      state_d = ST_HALT;
          else if (bus_ack_i) state_d = ST_RUN;
        end
        ST_RUN:   if (sw_req_i)  state_d = ST_SWRST;
        ST_SWRST: if (sw_done_i) state_d = ST_RUN;
        ST_HALT:  state_d = ST_HALT;
        default:  state_d = ST_HALT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_INIT;
      fstart_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      fstart_q <= (state_d == ST_FETCH) && (state_q != ST_FETCH);
    end
  end

  assign state_o       = state_q;
  assign fetch_start_o = fstart_q;

  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HALT && !rst_req_i) |=> state_q == ST_HALT); // R7
  AST_RST_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> state_q == ST_INIT); // R4
  AST_SW_FROM_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_SWRST) |-> $past(state_q) == ST_RUN); // R9
  AST_FSTART_IN_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fstart_q |-> state_q == ST_FETCH); // R3

endmodule

// File: rtl/cpu_rst_seq_regs.sv
module cpu_rst_seq_regs
  import cpu_rst_seq_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            init_i,
  input  logic            ld_ssp_i,
  input  logic            ld_pc_i,
  input  logic            hold_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [SR_W-1:0] sr_o,
  output logic [DW-1:0]   vbr_o,
  output logic [DW-1:0]   ssp_o,
  output logic [DW-1:0]   pc_o
);

  logic [SR_W-1:0] sr_q;
  logic [DW-1:0]   vbr_q, ssp_q, pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= sr_reset_val();
      vbr_q <= '0;
      ssp_q <= '0;
      pc_q  <= '0;
    end else begin
      if (init_i) begin
        sr_q  <= sr_reset_val();
        vbr_q <= '0;
      end
      if (ld_ssp_i) ssp_q <= wdata_i;
      if (ld_pc_i)  pc_q  <= wdata_i;
    end
  end

  assign sr_o  = sr_q;
  assign vbr_o = vbr_q;
  assign ssp_o = ssp_q;
  assign pc_o  = pc_q;

  AST_INIT_ARCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (sr_q == 16'h2700 && vbr_q == '0)); // R1
  AST_SW_REGS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> ($stable(sr_q) && $stable(vbr_q) && $stable(ssp_q) && $stable(pc_q))); // R8

endmodule

// File: rtl/cpu_rst_seq_bus.sv
module cpu_rst_seq_bus
  import cpu_rst_seq_pkg::*;
#(
  parameter int unsigned AW      = 32,
  parameter int unsigned VEC_NUM = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  seq_state_e    state_i,
  input  logic [AW-1:0] vbr_i,
  input  logic [AW-1:0] pc_i,
  input  logic          ack_i,
  input  logic          err_i,
  input  logic          rst_req_i,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output logic          ifetch_o
);

  localparam int unsigned LW_BYTES = 4;
  localparam logic [AW-1:0] VEC_OFS = AW'(VEC_NUM * LW_BYTES);
  localparam logic [AW-1:0] LW_OFS  = AW'(LW_BYTES);

  always_comb begin
    req_o    = 1'b0;
    addr_o   = '0;
    ifetch_o = 1'b0;
    case (state_i)
      ST_RD_SP: begin
        req_o  = 1'b1;
        addr_o = vbr_i + VEC_OFS;
      end
      ST_RD_PC: begin
        req_o  = 1'b1;
        addr_o = vbr_i + VEC_OFS + LW_OFS;
      end
      ST_FETCH: begin
        req_o    = 1'b1;
        addr_o   = pc_i;
        ifetch_o = 1'b1;
      end
      default: ;
    endcase
  end

  AST_BUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i && !err_i && !rst_req_i) |=> (req_o && $stable(addr_o))); // R2
  AST_FETCH_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ifetch_o) |-> !addr_o[0]); // R6

endmodule

// File: rtl/cpu_rst_seq_swrst.sv
module cpu_rst_seq_swrst #(
  parameter int unsigned RST_CYCLES = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  output logic ext_rst_o,
  output logic last_o,
  output logic done_o
);

  localparam int unsigned CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign last_o    = active_i && (cnt_q == LAST);
  assign ext_rst_o = active_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= (active_i && !last_o) ? cnt_q + CW'(1) : '0;
      done_q <= last_o;
    end
  end

  assign done_o = done_q;

  AST_SW_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> cnt_q < CW'(RST_CYCLES)); // R8
  AST_DONE_AFTER_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $fell(ext_rst_o)); // R8

endmodule

// File: rtl/cpu_rst_seq.sv
module cpu_rst_seq
  import cpu_rst_seq_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter int unsigned RST_CYCLES = 512,
  parameter int unsigned VEC_NUM    = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ext_rst_req_i,
  input  logic          int_rst_req_i,
  input  logic          sw_rst_req_i,
  output logic          bus_req_o,
  output logic [DW-1:0] bus_addr_o,
  output logic          bus_ifetch_o,
  input  logic          bus_ack_i,
  input  logic          bus_err_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic [15:0]   sr_o,
  output logic [DW-1:0] vbr_o,
  output logic [DW-1:0] ssp_o,
  output logic [DW-1:0] pc_o,
  output logic          fetch_start_o,
  output logic          run_o,
  output logic          halt_o,
  output logic          ext_rst_o,
  output logic          sw_rst_done_o
);

  seq_state_e state;
  logic       rst_req, sw_last, ack_ok;

  assign rst_req = ext_rst_req_i | int_rst_req_i;
  assign ack_ok  = bus_ack_i && !bus_err_i && !rst_req;

  cpu_rst_seq_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rst_req_i     (rst_req),
    .bus_ack_i     (bus_ack_i),
    .bus_err_i     (bus_err_i),
    .addr_odd_i    (bus_rdata_i[0]),
    .sw_req_i      (sw_rst_req_i),
    .sw_done_i     (sw_last),
    .state_o       (state),
    .fetch_start_o (fetch_start_o)
  );

  cpu_rst_seq_regs #(.DW(DW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .init_i   (state == ST_INIT),
    .ld_ssp_i (state == ST_RD_SP && ack_ok),
    .ld_pc_i  (state == ST_RD_PC && ack_ok),
    .hold_i   (state == ST_SWRST && !rst_req),
    .wdata_i  (bus_rdata_i),
    .sr_o     (sr_o),
    .vbr_o    (vbr_o),
    .ssp_o    (ssp_o),
    .pc_o     (pc_o)
  );

  cpu_rst_seq_bus #(.AW(DW), .VEC_NUM(VEC_NUM)) u_bus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state),
    .vbr_i     (vbr_o),
    .pc_i      (pc_o),
    .ack_i     (bus_ack_i),
    .err_i     (bus_err_i),
    .rst_req_i (rst_req),
    .req_o     (bus_req_o),
    .addr_o    (bus_addr_o),
    .ifetch_o  (bus_ifetch_o)
  );

  cpu_rst_seq_swrst #(.RST_CYCLES(RST_CYCLES)) u_swrst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (state == ST_SWRST),
    .ext_rst_o (ext_rst_o),
    .last_o    (sw_last),
    .done_o    (sw_rst_done_o)
  );

  assign run_o  = (state == ST_RUN) || (state == ST_SWRST);
  assign halt_o = (state == ST_HALT);

  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> (!bus_req_o && !ext_rst_o && !run_o)); // R5
  AST_ABORT_OUTPUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req |=> (!bus_req_o && !halt_o && !ext_rst_o)); // R4

endmodule

// File: tb/cpu_rst_seq_tb_top.sv
module cpu_rst_seq_tb_top;

  localparam int SW_CYC = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ext_rst_req_i = 1'b0, int_rst_req_i = 1'b0, sw_rst_req_i = 1'b0;
  logic        bus_ack_i = 1'b0, bus_err_i = 1'b0;
  logic [31:0] bus_rdata_i = '0;
  logic        bus_req_o, bus_ifetch_o, fetch_start_o, run_o, halt_o, ext_rst_o, sw_rst_done_o;
  logic [31:0] bus_addr_o, vbr_o, ssp_o, pc_o;
  logic [15:0] sr_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  cpu_rst_seq #(.RST_CYCLES(SW_CYC)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .ext_rst_req_i(ext_rst_req_i), .int_rst_req_i(int_rst_req_i), .sw_rst_req_i(sw_rst_req_i),
    .bus_req_o(bus_req_o), .bus_addr_o(bus_addr_o), .bus_ifetch_o(bus_ifetch_o),
    .bus_ack_i(bus_ack_i), .bus_err_i(bus_err_i), .bus_rdata_i(bus_rdata_i),
    .sr_o(sr_o), .vbr_o(vbr_o), .ssp_o(ssp_o), .pc_o(pc_o),
    .fetch_start_o(fetch_start_o), .run_o(run_o), .halt_o(halt_o),
    .ext_rst_o(ext_rst_o), .sw_rst_done_o(sw_rst_done_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual cycles=%0d expected below 100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // pulse a reset request for one cycle and check the abort (R4)
  task automatic do_req(input bit use_int);
    if (use_int) int_rst_req_i = 1'b1; else ext_rst_req_i = 1'b1;
    @(negedge clk);
    check("R4", "bus_req after abort", bus_req_o, 0);
    check("R4", "halt after abort", halt_o, 0);
    check("R4", "run after abort", run_o, 0);
    check("R4", "ext_rst after abort", ext_rst_o, 0);
    int_rst_req_i = 1'b0;
    ext_rst_req_i = 1'b0;
  endtask

  task automatic wait_req(input string rq);
    int k = 0;
    while (!bus_req_o && k < 20) begin @(negedge clk); k++; end
    check(rq, "bus_req seen", bus_req_o, 1);
  endtask

  task automatic serve(input string rq, input logic [31:0] exp_addr, input logic exp_if, input int waits,
                       input logic [31:0] data, input logic err, input logic exp_fs);
    wait_req(rq);
    check(rq, "addr", bus_addr_o, exp_addr);
    check(rq, "ifetch", bus_ifetch_o, exp_if);
    check("R3", "fetch_start first cycle", fetch_start_o, exp_fs);
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      check("R2", "req held", bus_req_o, 1);
      check("R2", "addr stable", bus_addr_o, exp_addr);
      check("R3", "fetch_start later cycle", fetch_start_o, 0);
    end
    bus_rdata_i = data;
    bus_ack_i   = !err;
    bus_err_i   = err;
    @(negedge clk);
    bus_ack_i   = 1'b0;
    bus_err_i   = 1'b0;
    bus_rdata_i = '0;
  endtask

  task automatic full_seq(input int w, input logic [31:0] sp, input logic [31:0] pc);
    serve("R2", 32'h0, 1'b0, w, sp, 1'b0, 1'b0);
    check("R1", "sr", sr_o, 32'h2700);
    check("R1", "vbr", vbr_o, 0);
    serve("R2", 32'h4, 1'b0, w, pc, 1'b0, 1'b0);
    serve("R3", pc, 1'b1, w, 32'h4e71_4e71, 1'b0, 1'b1);
    check("R3", "run", run_o, 1);
    check("R2", "ssp", ssp_o, sp);
    check("R2", "pc", pc_o, pc);
    check("R5", "halt", halt_o, 0);
  endtask

  task automatic halted_quiet(input string rq);
    check(rq, "halt", halt_o, 1);
    check(rq, "bus_req in halt", bus_req_o, 0);
    check(rq, "run in halt", run_o, 0);
    bus_ack_i = 1'b1;
    sw_rst_req_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R7", "halt sticky", halt_o, 1);
      check("R7", "ext_rst in halt", ext_rst_o, 0);
      check("R7", "bus_req in halt", bus_req_o, 0);
    end
    bus_ack_i = 1'b0;
    sw_rst_req_i = 1'b0;
  endtask

  task automatic sw_reset(input logic [31:0] sp, input logic [31:0] pc);
    int n = 0;
    sw_rst_req_i = 1'b1;
    @(negedge clk);
    sw_rst_req_i = 1'b0;
    while (ext_rst_o && n < 100) begin
      n++;
      check("R8", "no bus during sw reset", bus_req_o, 0);
      @(negedge clk);
    end
    check("R8", "ext_rst length", n, SW_CYC);
    check("R8", "done pulse", sw_rst_done_o, 1);
    check("R8", "ssp kept", ssp_o, sp);
    check("R8", "pc kept", pc_o, pc);
    check("R8", "sr kept", sr_o, 32'h2700);
    check("R8", "run after", run_o, 1);
    @(negedge clk);
    check("R8", "done single", sw_rst_done_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset sr", sr_o, 32'h2700);
    check("R1", "reset vbr", vbr_o, 0);
    check("R4", "reset bus_req", bus_req_o, 0);
    check("R5", "reset halt", halt_o, 0);
    rst_ni = 1'b1;
    full_seq(0, 32'h0000_8000, 32'h0000_0400);
    sw_reset(32'h0000_8000, 32'h0000_0400);

    // sweep of wait states and vector contents
    for (int w = 0; w < 4; w++) begin
      for (int p = 0; p < 4; p++) begin
        logic [31:0] sp, pc;
        sp = 32'h1000_0000 + 32'(w * 256) + 32'(p * 8);
        pc = (32'h0000_4000 ^ 32'(p << 12)) + 32'(w * 2);
        do_req(p[0]);
        full_seq(w, sp, pc);
      end
    end

    // bus error at each start-up cycle
    for (int st = 0; st < 3; st++) begin
      for (int w = 0; w < 2; w++) begin
        do_req(w[0]);
        serve("R5", 32'h0, 1'b0, w, 32'h0000_2000, st == 0, 1'b0);
        if (st > 0) serve("R5", 32'h4, 1'b0, w, 32'h0000_0800, st == 1, 1'b0);
        if (st > 1) serve("R5", 32'h0000_0800, 1'b1, w, 32'h0, 1'b1, 1'b1);
        halted_quiet("R5");
      end
    end

    // odd vector values
    do_req(1'b0);
    serve("R6", 32'h0, 1'b0, 1, 32'h0000_2001, 1'b0, 1'b0);
    halted_quiet("R6");
    do_req(1'b1);
    serve("R6", 32'h0, 1'b0, 0, 32'h0000_2000, 1'b0, 1'b0);
    serve("R6", 32'h4, 1'b0, 2, 32'h0000_0401, 1'b0, 1'b0);
    halted_quiet("R6");

    // sw reset request before run is ignored
    do_req(1'b0);
    sw_rst_req_i = 1'b1;
    serve("R9", 32'h0, 1'b0, 2, 32'h0000_3000, 1'b0, 1'b0);
    check("R9", "ext_rst before run", ext_rst_o, 0);
    sw_rst_req_i = 1'b0;
    serve("R9", 32'h4, 1'b0, 0, 32'h0000_0600, 1'b0, 1'b0);
    serve("R9", 32'h0000_0600, 1'b1, 0, 32'h0, 1'b0, 1'b1);
    check("R9", "run reached", run_o, 1);
    check("R9", "ext_rst idle", ext_rst_o, 0);

    // abort inside sw reset, then inside fetch
    sw_rst_req_i = 1'b1;
    @(negedge clk);
    sw_rst_req_i = 1'b0;
    repeat (2) @(negedge clk);
    check("R8", "ext_rst active", ext_rst_o, 1);
    do_req(1'b1);
    serve("R4", 32'h0, 1'b0, 0, 32'h0000_5000, 1'b0, 1'b0);
    serve("R4", 32'h4, 1'b0, 0, 32'h0000_0a00, 1'b0, 1'b0);
    wait_req("R4");
    check("R4", "fetch addr", bus_addr_o, 32'h0000_0a00);
    do_req(1'b0);
    full_seq(1, 32'h0000_6000, 32'h0000_0c00);
    check("R4", "new pc", pc_o, 32'h0000_0c00);
    sw_reset(32'h0000_6000, 32'h0000_0c00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule